// File: doc/BRIEF.md
# Frame Bitmap Allocator

This block keeps a record of which physical frames of a paged memory are occupied. Each of the 1024 frames has one bit in a map of 32 words, each 32 bits wide: a set bit means the frame is in use. A page-table walker or a memory manager sends it one request at a time. A request can mark a given frame as used or free. It can also find and claim the lowest-numbered free frame, or the lowest-numbered pair of adjacent free frames. A page table needs such a pair, and the pair may straddle two map words.

Every request ends with a one-cycle `done` pulse. With it come either the claimed frame's base address (frame index times 512) or a `full` flag when nothing fits. Frame 0 holds the segment table and is always reported as occupied. A search reads one map word per clock, so a claim takes between 2 and 33 cycles. While a search is running, `busy` is high and new requests are dropped.

Top module: `frame_bitmap_alloc`

## Requirements
- R1: After reset every frame is free except frame 0, `busy` and `done` are low, and the first single-frame claim returns frame 1 (base address 512).
- R2: A request with `req_op` = 2'b00 marks frame `req_frame` as used. `done` pulses one cycle after acceptance, with `full` = 0 and `base_addr` = `req_frame` × 512.
- R3: A request with `req_op` = 2'b01 marks frame `req_frame` as free, with the same completion timing and result as R2. A later search can then claim that frame again.
- R4: Frame 0 stays marked used at all times, and a request to free it has no effect.
- R5: `req_op` = 2'b10 claims the lowest-numbered free frame. The frame is marked used in the same step, and `base_addr` returns its index × 512.
- R6: `req_op` = 2'b11 claims the lowest start index f such that frames f and f+1 are both free, including pairs that cross a 32-frame word boundary. Both frames are marked used, and `base_addr` returns f × 512.
- R7: When no suitable frame or pair exists, `done` comes with `full` = 1 and `base_addr` = 0, and the map is left unchanged.
- R8: A search reads one map word per cycle, starting from word 0. A result found in word w (for a pair, the word holding its upper frame) arrives w+2 cycles after the request is presented. A failed search takes 33 cycles. `busy` is high for the whole scan and is never high together with `done`.
- R9: A request presented while `busy` is high is ignored and leaves the map untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only while not busy |
| req_op | input | 2 | 00 mark used, 01 mark free, 10 claim one frame, 11 claim a pair |
| req_frame | input | 10 | Frame index for the mark operations |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle completion pulse |
| full | output | 1 | With `done`: no suitable free frame was found |
| base_addr | output | 19 | With `done`: base address of the frame (index × 512) |

## Verification
Several rules are checked by the embedded assertions on every cycle. Frame 0 stays used. The scan pointer advances by exactly one word each cycle. `busy` and `done` never coincide. A `full` result leaves the whole map unchanged and reports address zero. A successful claim has already set the reported frame bits. Other behaviours show up only in the bench's scenarios: that the claimed frame is the lowest one, that a pair is found across a word boundary, that a freed frame can be claimed again, that a free request for frame 0 is dropped, and that a request arriving during a scan is ignored. The bench compares each result against its own reference map and also checks the latency of every request.

// File: rtl/frame_bitmap_alloc.sv
module frame_bitmap_alloc #(
  parameter int NUM_WORDS  = 32,
  parameter int WORD_W     = 32,
  parameter int PAGE_SHIFT = 9
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic                                              req_valid,
  input  logic [1:0]                                        req_op,
  input  logic [$clog2(NUM_WORDS*WORD_W)-1:0]               req_frame,
  output logic                                              busy,
  output logic                                              done,
  output logic                                              full,
  output logic [$clog2(NUM_WORDS*WORD_W)+PAGE_SHIFT-1:0]    base_addr
);
  localparam int FRAMES = NUM_WORDS * WORD_W;
  localparam int FIDX_W = $clog2(FRAMES);
  localparam int WIDX_W = $clog2(NUM_WORDS);
  localparam int BIDX_W = $clog2(WORD_W);
  localparam int ADDR_W = FIDX_W + PAGE_SHIFT;
  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(NUM_WORDS - 1);

  // frame f lives in word f/WORD_W at bit position WORD_W-1-(f%WORD_W): index 0 is the MSB
  logic [NUM_WORDS-1:0][WORD_W-1:0] map;
  logic              scanning, pair_q, carry_q;
  logic [WIDX_W-1:0] wptr;
  logic [1:0]        op_q;

  logic [WORD_W-1:0] cur;
  logic              hit1, hitp, hitb;
  logic [BIDX_W-1:0] pos1, posp, posp_n;
  logic [FIDX_W-1:0] bnd_frame;
  logic [WIDX_W-1:0] rw;
  logic [BIDX_W-1:0] rb;

  assign busy      = scanning;
  assign cur       = map[wptr];
  assign rw        = req_frame[FIDX_W-1:BIDX_W];
  assign rb        = ~req_frame[BIDX_W-1:0];
  assign posp_n    = posp + 1'b1;
  assign bnd_frame = {wptr, {BIDX_W{1'b0}}} - FIDX_W'(1);
  assign hitb      = carry_q && !cur[WORD_W-1];

  always_comb begin
    hit1 = 1'b0;
    pos1 = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (!cur[WORD_W-1-i]) begin
        hit1 = 1'b1;
        pos1 = BIDX_W'(i);
      end
    end
  end

  always_comb begin
    hitp = 1'b0;
    posp = '0;
    for (int i = WORD_W - 2; i >= 0; i--) begin
      if (!cur[WORD_W-1-i] && !cur[WORD_W-2-i]) begin
        hitp = 1'b1;
        posp = BIDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map                <= '0;
      map[0][WORD_W-1]   <= 1'b1;
      scanning           <= 1'b0;
      pair_q             <= 1'b0;
      carry_q            <= 1'b0;
      wptr               <= '0;
      op_q               <= '0;
      done               <= 1'b0;
      full               <= 1'b0;
      base_addr          <= '0;
    end else begin
      done <= 1'b0;
      if (!scanning) begin
        if (req_valid) begin
          op_q <= req_op;
          case (req_op)
            2'b00: begin
              map[rw][rb] <= 1'b1;
              done        <= 1'b1;
              full        <= 1'b0;
              base_addr   <= {req_frame, {PAGE_SHIFT{1'b0}}};
            end
            2'b01: begin
              if (req_frame != '0) map[rw][rb] <= 1'b0;
              done      <= 1'b1;
              full      <= 1'b0;
              base_addr <= {req_frame, {PAGE_SHIFT{1'b0}}};
            end
            default: begin
              scanning <= 1'b1;
              pair_q   <= req_op[0];
              wptr     <= '0;
              carry_q  <= 1'b0;
            end
          endcase
        end
      end else if (!pair_q && hit1) begin
        map[wptr][~pos1] <= 1'b1;
        done      <= 1'b1;
        full      <= 1'b0;
        base_addr <= {wptr, pos1, {PAGE_SHIFT{1'b0}}};
        scanning  <= 1'b0;
      end else if (pair_q && hitb) begin
        map[wptr - 1'b1][0]    <= 1'b1;
        map[wptr][WORD_W-1]    <= 1'b1;
        done      <= 1'b1;
        full      <= 1'b0;
        base_addr <= {bnd_frame, {PAGE_SHIFT{1'b0}}};
        scanning  <= 1'b0;
      end else if (pair_q && hitp) begin
        map[wptr][~posp]   <= 1'b1;
        map[wptr][~posp_n] <= 1'b1;
        done      <= 1'b1;
        full      <= 1'b0;
        base_addr <= {wptr, posp, {PAGE_SHIFT{1'b0}}};
        scanning  <= 1'b0;
      end else if (wptr == LAST_WORD) begin
        done      <= 1'b1;
        full      <= 1'b1;
        base_addr <= '0;
        scanning  <= 1'b0;
      end else begin
        wptr    <= wptr + 1'b1;
        carry_q <= !cur[0];
      end
    end
  end

  logic [FIDX_W-1:0] res_f, res_f1;
  assign res_f  = base_addr[ADDR_W-1:PAGE_SHIFT];
  assign res_f1 = res_f + 1'b1;

  // R4
  frame0_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    map[0][WORD_W-1]);

  // R7
  full_keeps_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && full) |-> (base_addr == '0 && $stable(map)));

  // R8
  scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (wptr == $past(wptr) + 1'b1));

  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R5
  claim_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !full && op_q[1]) |-> map[res_f[FIDX_W-1:BIDX_W]][~res_f[BIDX_W-1:0]]);

  // R6
  pair_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !full && op_q == 2'b11) |-> map[res_f1[FIDX_W-1:BIDX_W]][~res_f1[BIDX_W-1:0]]);
endmodule

// File: tb/test_frame_bitmap_alloc.sv
`timescale 1ns/1ps
module test_frame_bitmap_alloc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [9:0]  req_frame = '0;
  logic        busy, done, full;
  logic [18:0] base_addr;

  always #2.5 clk = ~clk;

  frame_bitmap_alloc i_frame_bitmap_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_frame(req_frame), .busy(busy), .done(done), .full(full),
    .base_addr(base_addr)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit model [1024];
  logic [19:0] exp_q [$];
  string       tag_q [$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int first_free();
    for (int f = 0; f < 1024; f++) if (!model[f]) return f;
    return -1;
  endfunction

  function automatic int first_pair();
    for (int f = 0; f < 1023; f++) if (!model[f] && !model[f+1]) return f;
    return -1;
  endfunction

  // monitor: pops one expected result per done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected done", {12'b0, full, base_addr}, 32'h0);
      end else begin
        logic [19:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({full, base_addr} == e, t, {12'b0, full, base_addr}, {12'b0, e});
      end
    end
  end

  task automatic run_op(input logic [1:0] op, input int fr, input string tag);
    int f;
    int lat;
    int cnt;
    logic [19:0] e;
    case (op)
      2'b00: begin model[fr] = 1'b1; e = {1'b0, 19'(fr) << 9}; lat = 1; end
      2'b01: begin if (fr != 0) model[fr] = 1'b0; e = {1'b0, 19'(fr) << 9}; lat = 1; end
      2'b10: begin
        f = first_free();
        if (f < 0) begin e = {1'b1, 19'd0}; lat = 33; end
        else begin model[f] = 1'b1; e = {1'b0, 19'(f) << 9}; lat = f / 32 + 2; end
      end
      default: begin
        f = first_pair();
        if (f < 0) begin e = {1'b1, 19'd0}; lat = 33; end
        else begin
          model[f] = 1'b1; model[f+1] = 1'b1;
          e = {1'b0, 19'(f) << 9}; lat = (f + 1) / 32 + 2;
        end
      end
    endcase
    exp_q.push_back(e);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_op = op; req_frame = 10'(fr);
    cnt = 0;
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      cnt++;
      if (done || cnt > 40) break;
    end
    check(cnt == lat, op[1] ? "R8 search latency" : "R2 mark latency", cnt, lat);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int f = 0; f < 1024; f++) model[f] = 1'b0;
    model[0] = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0 && done == 1'b0, "R1 idle after reset", {busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(2'b10, 0, "R1 first claim skips frame 0");
    run_op(2'b11, 0, "R6 first pair");
    for (int f = 4; f <= 30; f++) run_op(2'b00, f, "R2 mark used");
    run_op(2'b11, 0, "R6 pair across word boundary");
    run_op(2'b01, 2, "R3 free frame");
    run_op(2'b10, 0, "R3 freed frame reclaimed");
    run_op(2'b01, 0, "R4 free of frame 0");
    run_op(2'b10, 0, "R4 frame 0 not reclaimed");
    for (int f = 1; f < 1024; f++) run_op(2'b00, f, "R2 fill map");
    run_op(2'b10, 0, "R7 single on full map");
    run_op(2'b11, 0, "R7 pair on full map");
    run_op(2'b01, 500, "R3 free 500");
    run_op(2'b01, 502, "R3 free 502");
    run_op(2'b11, 0, "R7 no adjacent pair");
    run_op(2'b10, 0, "R5 lowest free 500");
    run_op(2'b10, 0, "R5 next free 502");

    // R9: request during a scan is dropped
    run_op(2'b01, 1000, "R3 free 1000");
    model[1000] = 1'b1;
    exp_q.push_back({1'b0, 19'd1000 << 9});
    tag_q.push_back("R9 claim during ignored request");
    req_valid = 1'b1; req_op = 2'b10; req_frame = '0;
    @(negedge clk);
    check(busy == 1'b1, "R8 busy during scan", busy, 1);
    req_op = 2'b01; req_frame = 10'd5;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 40 && !done; k++) @(negedge clk);
    run_op(2'b10, 0, "R9 ignored free had no effect");

    run_op(2'b01, 1022, "R3 free 1022");
    run_op(2'b01, 1023, "R3 free 1023");
    run_op(2'b11, 0, "R6 pair at top of map");
    run_op(2'b10, 0, "R7 full again");

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R8 all results seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule